// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block picks, once per cell slot, a set of input-to-output connections for an N-port input-queued cell switch. No input and no output appears in more than one connection. Each input holds one queue per output, and the block keeps one bit per queue saying whether that queue holds cells. Inputs flip those bits through a small update port whenever a queue goes empty or becomes non-empty.

A slot begins with a one-cycle start pulse. The block copies the live occupancy bits, then runs a fixed number of request/grant/accept rounds, one round per clock. Every output owns a round-robin grant arbiter and every input owns a round-robin accept arbiter. Each arbiter keeps a pointer that survives from slot to slot. The pointers move only on connections formed in the first round of a slot. This pushes the output arbiters apart over time, so they stop granting to the same input. At the end of the slot a one-cycle done pulse presents, for every input, a valid flag and the index of its output. The switch fabric uses these to set up the crossbar for the next cell time.

Top module: `xbar_rr_matcher`

## Requirements
- R1: An update on input i with `upd_vld[i]`=1 writes `upd_nonempty[i]` into the occupancy bit for (input i, output `upd_oidx[i*W +: W]`) at the clock edge. Each input writes only its own row.
- R2: The rounds of a slot use the occupancy as it stood just before the start edge. Updates made while the slot runs, or in the same cycle as the start, only affect later slots.
- R3: When idle, `slot_start`=1 raises `busy` after the edge, with `iter_idx`=0. `iter_idx` then counts up by one per cycle. `match_done` is high for exactly one cycle, ITERS cycles after the start edge, and `busy` is low in that cycle. A `slot_start` that arrives while busy is ignored.
- R4: In each round, every output not yet matched grants exactly one request from an unmatched input whose occupancy bit is set. It picks the first such input at or after its grant pointer, in increasing index order with wrap-around modulo N.
- R5: Every input that receives grants accepts the first granting output at or after its accept pointer, in increasing index order modulo N.
- R6: All pointers reset to 0. A connection formed in the first round sets the output's grant pointer to (input+1) mod N and the input's accept pointer to (output+1) mod N. Connections formed in later rounds, and slots with no match, leave every pointer unchanged.
- R7: Inputs and outputs matched in an earlier round sit out later rounds. Matches are never undone within a slot. The final result is conflict-free: every output serves at most one input.
- R8: At `match_done`, `match_vld[i]`=1 means input i is matched to output `match_oidx[i*W +: W]`. An unmatched input reports `match_vld[i]`=0 and index 0. The result holds until the next `match_done`.
- R9: The round count ITERS is a parameter. One round and four rounds per slot both give the behaviour above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_vld | input | N | Per-input occupancy update strobe |
| upd_oidx | input | N*W | Per-input output index of the updated queue |
| upd_nonempty | input | N | New occupancy value for the updated queue |
| slot_start | input | 1 | One-cycle pulse that begins a slot |
| busy | output | 1 | Rounds in progress |
| iter_idx | output | ITW | Index of the round being evaluated |
| match_done | output | 1 | One-cycle pulse: result valid |
| match_vld | output | N | Per-input matched flag |
| match_oidx | output | N*W | Per-input matched output index |

## Verification
The bench goes after the first slots after reset. There all pointers sit at zero and a full request matrix must match input k to output k in round k. A design that moved pointers in later rounds, or started arbitration one place past the pointer, gives a different pairing. Repeated full-load slots check that the output pointers spread apart, which a design that updated pointers on unaccepted grants would not do. Single-column and single-row patterns, where only one match is possible, expose designs that let an output serve two inputs or drop a match made earlier. An occupancy change made mid-slot, and a second start pulse while busy, catch designs that read live occupancy or restart the round counter. A one-round instance run alongside a four-round one shows where the round count really ends the slot.

// File: rtl/xbar_rr_pkg.sv
`timescale 1ns/1ps
package xbar_rr_pkg;

  // index width that stays at least one bit for degenerate counts
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/xbar_occ_map.sv
`timescale 1ns/1ps
module xbar_occ_map #(
  parameter  int N = 4,
  localparam int W = xbar_rr_pkg::idx_w(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   upd_vld,
  input  logic [N*W-1:0] upd_oidx,
  input  logic [N-1:0]   upd_nonempty,
  output logic [N*N-1:0] occ
);

  // one row per input; each input owns its row, so rows never collide
  for (genvar gi = 0; gi < N; gi++) begin : g_row
    logic [N-1:0] row_q;
    logic [W-1:0] sel;
    assign sel = upd_oidx[gi*W +: W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (upd_vld[gi] && (int'(sel) < N)) begin
        row_q[sel] <= upd_nonempty[gi];
      end
    end

    assign occ[gi*N +: N] = row_q;
  end

endmodule

// File: rtl/xbar_rr_arb.sv
`timescale 1ns/1ps
module xbar_rr_arb #(
  parameter  int N = 4,
  localparam int W = xbar_rr_pkg::idx_w(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [N-1:0] gnt,
  output logic [W-1:0] gnt_idx,
  output logic         any
);

  // position k places after the pointer, wrapped into 0..N-1
  function automatic logic [W-1:0] wrap_idx(input logic [W-1:0] base, input int step);
    int s;
    s = int'(base) + step;
    if (s >= N) s = s - N;
    return W'(s);
  endfunction

  // programmable-priority encoder: pointer holds the highest priority slot
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_idx(ptr, k)]) begin
        any     = 1'b1;
        gnt_idx = wrap_idx(ptr, k);
      end
    end
    if (any) gnt[gnt_idx] = 1'b1;
  end

endmodule

// File: rtl/xbar_slot_seq.sv
`timescale 1ns/1ps
module xbar_slot_seq #(
  parameter  int ITERS = 4,
  localparam int ITW   = xbar_rr_pkg::idx_w(ITERS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_start,
  output logic           busy,
  output logic [ITW-1:0] iter_idx,
  output logic           launch,
  output logic           first_iter,
  output logic           last_iter,
  output logic           done
);

  localparam logic [ITW-1:0] LAST_IT = ITW'(ITERS - 1);

  xbar_rr_pkg::seq_state_e state_q;
  logic [ITW-1:0]          iter_q;
  logic                    done_q;

  assign busy       = (state_q == xbar_rr_pkg::SEQ_RUN);
  assign iter_idx   = iter_q;
  assign launch     = slot_start && !busy;
  assign first_iter = busy && (iter_q == '0);
  assign last_iter  = busy && (iter_q == LAST_IT);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= xbar_rr_pkg::SEQ_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_iter;
      if (launch) begin
        state_q <= xbar_rr_pkg::SEQ_RUN;
        iter_q  <= '0;
      end else if (busy) begin
        if (last_iter) begin
          state_q <= xbar_rr_pkg::SEQ_IDLE;
          iter_q  <= '0;
        end else begin
          iter_q <= iter_q + ITW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_rr_matcher.sv
`timescale 1ns/1ps
module xbar_rr_matcher #(
  parameter  int N     = 4,
  parameter  int ITERS = 4,
  localparam int W     = xbar_rr_pkg::idx_w(N),
  localparam int ITW   = xbar_rr_pkg::idx_w(ITERS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   upd_vld,
  input  logic [N*W-1:0] upd_oidx,
  input  logic [N-1:0]   upd_nonempty,
  input  logic           slot_start,
  output logic           busy,
  output logic [ITW-1:0] iter_idx,
  output logic           match_done,
  output logic [N-1:0]   match_vld,
  output logic [N*W-1:0] match_oidx
);

  // one past an index, modulo N
  function automatic logic [W-1:0] step_ptr(input logic [W-1:0] idx);
    return (int'(idx) == N - 1) ? '0 : idx + W'(1);
  endfunction

  logic [N*N-1:0]        occ;
  logic [N*N-1:0]        snap_q;       // bit i*N+o: input i holds cells for output o
  logic [N-1:0]          in_done_q;
  logic [N-1:0]          out_done_q;
  logic [N-1:0][W-1:0]   gptr_q;
  logic [N-1:0][W-1:0]   aptr_q;
  logic [N-1:0][W-1:0]   work_idx_q;
  logic [N-1:0]          res_vld_q;
  logic [N-1:0][W-1:0]   res_idx_q;

  // named internal events for the checker
  logic [N-1:0][N-1:0]   gnt_mx;       // gnt_mx[o][i]: output o grants input i
  logic [N-1:0][N-1:0]   acc_mx;       // acc_mx[i][o]: input i accepts output o
  logic [N-1:0][W-1:0]   gnt_idx_o;
  logic [N-1:0]          gnt_any_o;
  logic [N-1:0][W-1:0]   acc_idx;
  logic [N-1:0]          acc_any;
  logic [N-1:0]          out_hit;

  logic launch, first_iter, last_iter;

  xbar_occ_map #(.N(N)) u_occ (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_vld      (upd_vld),
    .upd_oidx     (upd_oidx),
    .upd_nonempty (upd_nonempty),
    .occ          (occ)
  );

  xbar_slot_seq #(.ITERS(ITERS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .busy       (busy),
    .iter_idx   (iter_idx),
    .launch     (launch),
    .first_iter (first_iter),
    .last_iter  (last_iter),
    .done       (match_done)
  );

  // grant stage: one arbiter per output over the still-unmatched inputs
  for (genvar go = 0; go < N; go++) begin : g_grant
    logic [N-1:0] col_req;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        col_req[i] = snap_q[i*N + go] && !in_done_q[i] && !out_done_q[go];
      end
    end
    xbar_rr_arb #(.N(N)) u_garb (
      .req     (col_req),
      .ptr     (gptr_q[go]),
      .gnt     (gnt_mx[go]),
      .gnt_idx (gnt_idx_o[go]),
      .any     (gnt_any_o[go])
    );
  end

  // accept stage: one arbiter per input over the outputs that granted it
  for (genvar gi = 0; gi < N; gi++) begin : g_accept
    logic [N-1:0] row_gnt;
    always_comb begin
      for (int o = 0; o < N; o++) row_gnt[o] = gnt_mx[o][gi];
    end
    xbar_rr_arb #(.N(N)) u_aarb (
      .req     (row_gnt),
      .ptr     (aptr_q[gi]),
      .gnt     (acc_mx[gi]),
      .gnt_idx (acc_idx[gi]),
      .any     (acc_any[gi])
    );
  end

  // an output is matched this round when the input it granted accepted it
  always_comb begin
    for (int o = 0; o < N; o++) begin
      out_hit[o] = 1'b0;
      for (int i = 0; i < N; i++) out_hit[o] = out_hit[o] | acc_mx[i][o];
      out_hit[o] = out_hit[o] && gnt_any_o[o];
    end
  end

  // round state and persistent pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      in_done_q  <= '0;
      out_done_q <= '0;
      gptr_q     <= '0;
      aptr_q     <= '0;
      work_idx_q <= '0;
    end else if (launch) begin
      snap_q     <= occ;
      in_done_q  <= '0;
      out_done_q <= '0;
      work_idx_q <= '0;
    end else if (busy) begin
      in_done_q  <= in_done_q | acc_any;
      out_done_q <= out_done_q | out_hit;
      for (int i = 0; i < N; i++) begin
        if (acc_any[i]) work_idx_q[i] <= acc_idx[i];
      end
      if (first_iter) begin
        for (int o = 0; o < N; o++) begin
          if (out_hit[o]) gptr_q[o] <= step_ptr(gnt_idx_o[o]);
        end
        for (int i = 0; i < N; i++) begin
          if (acc_any[i]) aptr_q[i] <= step_ptr(acc_idx[i]);
        end
      end
    end
  end

  // result registers, loaded as the last round commits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= '0;
      res_idx_q <= '0;
    end else if (last_iter) begin
      res_vld_q <= in_done_q | acc_any;
      for (int i = 0; i < N; i++) begin
        if (acc_any[i])        res_idx_q[i] <= acc_idx[i];
        else if (in_done_q[i]) res_idx_q[i] <= work_idx_q[i];
        else                   res_idx_q[i] <= '0;
      end
    end
  end

  assign match_vld  = res_vld_q;
  assign match_oidx = res_idx_q;

endmodule

// File: rtl/xbar_rr_matcher_chk.sv
`timescale 1ns/1ps
module xbar_rr_matcher_chk #(
  parameter  int N     = 4,
  parameter  int ITERS = 4,
  localparam int W     = xbar_rr_pkg::idx_w(N),
  localparam int ITW   = xbar_rr_pkg::idx_w(ITERS)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           slot_start,
  input logic           busy,
  input logic [ITW-1:0] iter_idx,
  input logic           match_done,
  input logic [N*N-1:0] snap,
  input logic [N-1:0]   in_done,
  input logic [N*W-1:0] gptr,
  input logic [N*W-1:0] aptr,
  input logic [N*N-1:0] acc
);

  localparam logic [ITW-1:0] LAST_IT = ITW'(ITERS - 1);

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !busy |=> busy && (iter_idx == '0));

  // R3
  iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (iter_idx != LAST_IT) |=> busy && (iter_idx == $past(iter_idx) + ITW'(1)));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |=> !match_done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |-> !busy);

  // R2
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(snap));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (iter_idx == '0)) |=> $stable(gptr) && $stable(aptr));

  // R7
  keep_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((in_done & $past(in_done)) == $past(in_done)));

  for (genvar go = 0; go < N; go++) begin : g_col
    logic [N-1:0] col;
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
      assign col[gi] = acc[gi*N + go];
    end
    // R7
    out_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    // R5
    in_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc[gi*N +: N]));
  end

endmodule

bind xbar_rr_matcher xbar_rr_matcher_chk #(.N(N), .ITERS(ITERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_start (slot_start),
  .busy       (busy),
  .iter_idx   (iter_idx),
  .match_done (match_done),
  .snap       (snap_q),
  .in_done    (in_done_q),
  .gptr       (gptr_q),
  .aptr       (aptr_q),
  .acc        (acc_mx)
);

// File: tb/xbar_rr_matcher_tb.sv
`timescale 1ns/1ps
module xbar_rr_matcher_tb;
  localparam int N = 4;
  localparam int W = 2;
  typedef int parr_t [N];
  typedef struct packed { logic [15:0] occ; logic [7:0] cnt4; } vec_t;

  // occupancy bit i*4+o = input i has cells for output o; cnt4 = matches with four rounds
  localparam vec_t VECS [12] = '{
    '{16'hFFFF, 8'd4}, '{16'hFFFF, 8'd4}, '{16'h8421, 8'd4}, '{16'h1111, 8'd1},
    '{16'h000F, 8'd1}, '{16'h1248, 8'd4}, '{16'h0000, 8'd0}, '{16'h0033, 8'd2},
    '{16'hCC00, 8'd2}, '{16'h00F0, 8'd1}, '{16'h8000, 8'd1}, '{16'hFFFF, 8'd4}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] upd_vld = '0, upd_nonempty = '0;
  logic [N*W-1:0] upd_oidx = '0;
  logic slot_start = 1'b0, start1 = 1'b0;
  logic busy4, busy1, done4, done1;
  logic [1:0] iter4;
  logic [0:0] iter1;
  logic [N-1:0] vld4, vld1;
  logic [N*W-1:0] oidx4, oidx1;

  int checks = 0, fails = 0;
  logic [15:0] occ_m = '0;
  parr_t gp4, ap4, gp1, ap1;
  logic [N-1:0] last_v4, last_v1;
  logic [N*W-1:0] last_o4, last_o1;

  always #10 clk = ~clk;

  xbar_rr_matcher #(.N(N), .ITERS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_oidx(upd_oidx),
    .upd_nonempty(upd_nonempty), .slot_start(slot_start), .busy(busy4),
    .iter_idx(iter4), .match_done(done4), .match_vld(vld4), .match_oidx(oidx4));

  xbar_rr_matcher #(.N(N), .ITERS(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_oidx(upd_oidx),
    .upd_nonempty(upd_nonempty), .slot_start(start1), .busy(busy1),
    .iter_idx(iter1), .match_done(done1), .match_vld(vld1), .match_oidx(oidx1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference matcher, written from the requirements
  task automatic model(input int iters, input logic [15:0] oc, inout parr_t gp, inout parr_t ap,
                       output logic [N-1:0] ev, output logic [N*W-1:0] eo);
    bit im [N];
    bit om [N];
    for (int k = 0; k < N; k++) begin im[k] = 0; om[k] = 0; end
    ev = '0; eo = '0;
    for (int it = 0; it < iters; it++) begin
      int g [N];
      int a [N];
      for (int o = 0; o < N; o++) begin
        g[o] = -1;
        for (int k = 0; k < N; k++) begin
          int i;
          i = (gp[o] + k) % N;
          if (!om[o] && g[o] < 0 && !im[i] && oc[i*N+o]) g[o] = i;
        end
      end
      for (int i = 0; i < N; i++) begin
        a[i] = -1;
        for (int k = 0; k < N; k++) begin
          int o;
          o = (ap[i] + k) % N;
          if (!im[i] && a[i] < 0 && g[o] == i) a[i] = o;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (a[i] >= 0) begin
          im[i] = 1; om[a[i]] = 1; ev[i] = 1'b1; eo[i*W +: W] = W'(a[i]);
          if (it == 0) begin ap[i] = (a[i] + 1) % N; gp[a[i]] = (i + 1) % N; end
        end
      end
    end
  endtask

  // R1: one output column per cycle, every input writes its own row
  task automatic load_occ(input logic [15:0] tgt);
    for (int o = 0; o < N; o++) begin
      @(negedge clk);
      upd_vld = '1;
      for (int i = 0; i < N; i++) begin
        upd_oidx[i*W +: W] = W'(o);
        upd_nonempty[i] = tgt[i*N+o];
      end
    end
    @(negedge clk);
    upd_vld = '0;
    occ_m = tgt;
  endtask

  task automatic run_slot(input bit do_mid, input bit do_restart);
    logic [N-1:0] ev4, ev1;
    logic [N*W-1:0] eo4, eo1;
    model(4, occ_m, gp4, ap4, ev4, eo4);
    model(1, occ_m, gp1, ap1, ev1, eo1);
    @(negedge clk); slot_start = 1'b1; start1 = 1'b1;
    @(negedge clk); slot_start = 1'b0; start1 = 1'b0;
    chk(busy4 == 1'b1, "R3 busy after start", 32'(busy4), 1);
    chk(iter4 == 2'd0, "R3 first round index", 32'(iter4), 0);
    if (do_mid) begin
      upd_vld = 4'b0001; upd_oidx = '0; upd_nonempty = {3'b000, ~occ_m[0]};
      occ_m[0] = ~occ_m[0];
    end
    @(negedge clk);
    upd_vld = '0;
    chk(done1 == 1'b1, "R9 one-round done", 32'(done1), 1);
    chk(vld1 == ev1, "R4 R9 one-round valid", 32'(vld1), 32'(ev1));
    chk(oidx1 == eo1, "R5 R9 one-round index", 32'(oidx1), 32'(eo1));
    chk(iter4 == 2'd1, "R3 round count", 32'(iter4), 1);
    if (do_restart) slot_start = 1'b1;
    @(negedge clk); slot_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done4 == 1'b1, "R3 done timing", 32'(done4), 1);
    chk(busy4 == 1'b0, "R3 idle at done", 32'(busy4), 0);
    chk(vld4 == ev4, "R4 R7 valid", 32'(vld4), 32'(ev4));
    chk(oidx4 == eo4, "R5 R8 index", 32'(oidx4), 32'(eo4));
    last_v4 = vld4; last_o4 = oidx4; last_v1 = vld1; last_o1 = oidx1;
    @(negedge clk);
    chk(done4 == 1'b0, "R3 done one cycle", 32'(done4), 0);
    chk(busy4 == 1'b0, "R3 no restart", 32'(busy4), 0);
    chk(vld4 == ev4, "R8 result held", 32'(vld4), 32'(ev4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy4 == 1'b0, "R3 reset busy", 32'(busy4), 0);
    chk(done4 == 1'b0, "R3 reset done", 32'(done4), 0);
    chk(vld4 == '0, "R8 reset valid", 32'(vld4), 0);
    chk(iter4 == '0, "R3 reset round", 32'(iter4), 0);
    rst_n = 1'b1;

    // R6: pointers at zero, full load pairs input k with output k in round k
    load_occ(16'hFFFF);
    run_slot(1'b0, 1'b0);
    chk(last_v4 == 4'hF, "R6 first slot valid", 32'(last_v4), 32'hF);
    chk(last_o4 == 8'hE4, "R6 first slot diagonal", 32'(last_o4), 32'hE4);
    chk(last_v1 == 4'h1, "R9 one round single match", 32'(last_v1), 32'h1);
    chk(last_o1 == 8'h00, "R9 one round index", 32'(last_o1), 32'h0);

    // R1 R4 R5 R7: table walk
    for (int v = 0; v < 12; v++) begin
      load_occ(VECS[v].occ);
      run_slot(1'b0, 1'b0);
      chk($countones(last_v4) == int'(VECS[v].cnt4), "R7 match count",
          32'($countones(last_v4)), 32'(VECS[v].cnt4));
    end

    // R8: no requests gives no match and index zero
    load_occ(16'h0000);
    run_slot(1'b0, 1'b0);
    chk(last_v4 == '0 && last_o4 == '0, "R8 empty slot", 32'({last_v4, last_o4}), 0);

    // R2: change made mid-slot is not seen until the following slot
    load_occ(16'h0001);
    run_slot(1'b1, 1'b0);
    chk(last_v4 == 4'h1, "R2 snapshot used", 32'(last_v4), 32'h1);
    run_slot(1'b0, 1'b0);
    chk(last_v4 == 4'h0, "R1 R2 cleared bit next slot", 32'(last_v4), 32'h0);

    // R3: start pulse while busy is ignored
    load_occ(16'h8421);
    run_slot(1'b0, 1'b1);
    run_slot(1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule